// File: doc/BRIEF.md
# Reloading Modulus Down-Counter

This block is a 16-bit down-counter that advances once per tick of a small clock divider. It keeps a second 16-bit word, the reload value, next to the live count. In periodic mode the count runs from the reload value down to one. On the next tick it wraps back to the reload value and raises a sticky zero flag. In single-run mode it counts down to zero, raises the flag and then stays at zero.

Software reaches the block through a word-wide write port and a word-wide read port. A select input chooses whether a read returns the live count or the reload value. The effect of a write depends on the mode. In periodic mode a write only replaces the reload value, and the running period ends undisturbed. In single-run mode a write restarts the count at once from the written value and clears the divider. A force strobe copies the reload value into the count without waiting for the period to end. Writing zero parks the count at zero without raising the flag. When both capture-latch controls are set, a zero write also sends a one-cycle request to the capture registers outside the block.

Top module: `moddown_timer`

## Requirements
- R1: After reset the count and the reload value both read 0xFFFF, and the zero flag and the latch request are both 0.
- R2: `rd_data` shows the live count when `rd_sel` is 0 and the reload value when `rd_sel` is 1. It changes in the same cycle as `rd_sel`, with no clock edge needed.
- R3: `presc_sel` sets the divider: 0 gives divide-by-1, 1 gives 4, 2 gives 8 and 3 gives 16. The count drops by one on each divider tick while it is enabled and not zero.
- R4: In single-run mode (`periodic_mode`=0), a write loads both the reload value and the count at the clock edge and clears the divider. The count then runs down to 0 and stays there.
- R5: In periodic mode a write changes only the reload value, and the count carries on with its current period.
- R6: In periodic mode, the tick that finds the count at 1 loads the count with the reload value. This includes a reload value written in that same cycle.
- R7: The zero flag is set by the tick that ends a period, meaning the count leaves 1. The flag stays set until `flag_clr` is pulsed, and a set in the same cycle wins over a clear.
- R8: A write of 0x0000 in either mode puts the count at zero at that edge and does not set the zero flag. The count then stays at zero.
- R9: `latch_req` is high for exactly the one cycle after a write of 0x0000 made while `latch_en` and `buf_en` are both 1. It stays low otherwise.
- R10: `force_load` copies the reload value into the count at the next edge and clears the divider. If a write happens in the same cycle, the copy uses the written value.
- R11: While `cnt_en` is 0, the count and the divider both hold their values. Writes still take effect as set out for their mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Word write strobe |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read source: 0 live count, 1 reload value |
| rd_data | output | 16 | Read data |
| cnt_en | input | 1 | Count enable |
| periodic_mode | input | 1 | 1 periodic reload, 0 single run |
| presc_sel | input | 2 | Divider select |
| force_load | input | 1 | Copy the reload value into the count now |
| flag_clr | input | 1 | Clear the zero flag |
| latch_en | input | 1 | Capture latch enable |
| buf_en | input | 1 | Capture buffer enable |
| zero_flag | output | 1 | Sticky end-of-period flag |
| latch_req | output | 1 | One-cycle capture latch request |

## Verification
Two events can land on the same edge: the count wrapping from 1 in periodic mode, and a software write together with a flag clear. The bench runs the count down to 1 with the divider at 1. It then applies a new reload value and a `flag_clr` pulse in exactly the cycle of the wrap. The result is judged correct only if the count takes the freshly written value and the flag ends up set. A second coincidence is checked as well: a write and a force strobe in the same cycle must leave the count holding the written word.

// File: rtl/mdc_pkg.sv
`timescale 1ns/1ps
package mdc_pkg;
    localparam int PRESC_W = 4;

    typedef enum logic [1:0] {
        DIV_1  = 2'd0,
        DIV_4  = 2'd1,
        DIV_8  = 2'd2,
        DIV_16 = 2'd3
    } presc_e;

    // Last divider state before a tick, for each divide ratio.
    function automatic logic [PRESC_W-1:0] presc_limit(input presc_e s);
        case (s)
            DIV_1:   presc_limit = PRESC_W'(0);
            DIV_4:   presc_limit = PRESC_W'(3);
            DIV_8:   presc_limit = PRESC_W'(7);
            default: presc_limit = PRESC_W'(15);
        endcase
    endfunction
endpackage

// File: rtl/mdc_prescaler.sv
`timescale 1ns/1ps
module mdc_prescaler
    import mdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       clr,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [PRESC_W-1:0] presc_d, presc_q;
    logic [PRESC_W-1:0] limit;

    always_comb begin
        limit   = presc_limit(presc_e'(sel));
        tick    = en && (presc_q >= limit);
        presc_d = presc_q;
        if (clr)
            presc_d = '0;
        else if (en)
            presc_d = tick ? '0 : presc_q + PRESC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_d;
    end

    // R3
    presc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !tick) |=> (presc_q == $past(presc_q) + PRESC_W'(1)));

    // R11
    presc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(presc_q));
endmodule

// File: rtl/mdc_readmux.sv
`timescale 1ns/1ps
module mdc_readmux #(
    parameter int W = 16
) (
    input  logic         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] reload,
    output logic [W-1:0] q
);
    always_comb q = sel ? reload : live;
endmodule

// File: rtl/moddown_timer.sv
`timescale 1ns/1ps
module moddown_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [CNT_W-1:0] rd_data,
    input  logic             cnt_en,
    input  logic             periodic_mode,
    input  logic [1:0]       presc_sel,
    input  logic             force_load,
    input  logic             flag_clr,
    input  logic             latch_en,
    input  logic             buf_en,
    output logic             zero_flag,
    output logic             latch_req
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] load;
        logic             flag;
        logic             latch;
    } state_t;

    state_t st_d, st_q;
    logic   tick;
    logic   presc_clr;
    logic   wr_zero;

    mdc_prescaler u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cnt_en),
        .clr   (presc_clr),
        .sel   (presc_sel),
        .tick  (tick)
    );

    always_comb begin
        st_d      = st_q;
        presc_clr = 1'b0;
        wr_zero   = wr_en && (wr_data == '0);
        if (wr_en)    st_d.load = wr_data;
        if (flag_clr) st_d.flag = 1'b0;
        st_d.latch = wr_zero && latch_en && buf_en;
        if (wr_zero) begin
            st_d.cnt  = '0;
            presc_clr = 1'b1;
        end else if (wr_en && !periodic_mode) begin
            st_d.cnt  = wr_data;
            presc_clr = 1'b1;
        end else if (force_load) begin
            st_d.cnt  = st_d.load;
            presc_clr = 1'b1;
        end else if (cnt_en && tick && (st_q.cnt != '0)) begin
            if (st_q.cnt == ONE) begin
                st_d.flag = 1'b1;
                st_d.cnt  = periodic_mode ? st_d.load : '0;
            end else begin
                st_d.cnt  = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '1;
            st_q.load  <= '1;
            st_q.flag  <= 1'b0;
            st_q.latch <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    mdc_readmux #(.W(CNT_W)) u_rdmux (
        .sel    (rd_sel),
        .live   (st_q.cnt),
        .reload (st_q.load),
        .q      (rd_data)
    );

    assign zero_flag = st_q.flag;
    assign latch_req = st_q.latch;

    // R7
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_flag) |-> ($past(st_q.cnt) == ONE));

    // R8
    zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == '0 && !flag_clr) |=> (st_q.cnt == '0 && zero_flag == $past(zero_flag)));

    // R4
    oneshot_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic_mode && st_q.cnt == '0 && !wr_en && !force_load) |=> (st_q.cnt == '0));

    // R11
    hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr_en && !force_load) |=> $stable(st_q.cnt));

    // R9
    latch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_req |-> $past(wr_en && latch_en && buf_en));
endmodule

// File: tb/moddown_timer_tb.sv
`timescale 1ns/1ps
module moddown_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [15:0] rd_data;
    logic        cnt_en = 1'b0;
    logic        periodic_mode = 1'b0;
    logic [1:0]  presc_sel = 2'd0;
    logic        force_load = 1'b0;
    logic        flag_clr = 1'b0;
    logic        latch_en = 1'b0;
    logic        buf_en = 1'b0;
    logic        zero_flag;
    logic        latch_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    moddown_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .cnt_en(cnt_en),
        .periodic_mode(periodic_mode), .presc_sel(presc_sel),
        .force_load(force_load), .flag_clr(flag_clr), .latch_en(latch_en),
        .buf_en(buf_en), .zero_flag(zero_flag), .latch_req(latch_req)
    );

    typedef struct packed {
        logic [1:0]  psel;
        logic [15:0] val;
        logic [7:0]  wt;
        logic [15:0] expc;
        logic        eflag;
    } vec_t;

    // single-run writes: expected count = val - floor(wt/div), floored at 0
    localparam vec_t VECS [6] = '{
        '{2'd0, 16'd10, 8'd3,  16'd7, 1'b0},
        '{2'd1, 16'd10, 8'd8,  16'd8, 1'b0},
        '{2'd2, 16'd5,  8'd17, 16'd3, 1'b0},
        '{2'd3, 16'd3,  8'd33, 16'd1, 1'b0},
        '{2'd0, 16'd4,  8'd9,  16'd0, 1'b1},
        '{2'd1, 16'd2,  8'd20, 16'd0, 1'b1}
    };

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_cnt(input string req, input logic [15:0] exp);
        rd_sel = 1'b0; #1;
        chk(req, rd_data, exp);
    endtask

    task automatic rd_load(input string req, input logic [15:0] exp);
        rd_sel = 1'b1; #1;
        chk(req, rd_data, exp);
        rd_sel = 1'b0; #1;
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        // R1 reset state, R2 read source
        rd_cnt("R1 count", 16'hFFFF);
        rd_load("R1 R2 load", 16'hFFFF);
        chk("R1 flag", {15'd0, zero_flag}, 16'd0);
        chk("R1 latch", {15'd0, latch_req}, 16'd0);
        rst_n = 1'b1;
        cyc();

        // R3 R4 vector table, single-run mode
        cnt_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            presc_sel = VECS[i].psel;
            flag_clr = 1'b1;
            wr(VECS[i].val);
            flag_clr = 1'b0;
            repeat (int'(VECS[i].wt)) cyc();
            rd_cnt("R3 R4 count", VECS[i].expc);
            rd_load("R2 load", VECS[i].val);
            chk("R7 flag", {15'd0, zero_flag}, {15'd0, VECS[i].eflag});
        end

        // R11 divider holds while disabled
        presc_sel = 2'd1;
        wr(16'd10);
        cyc(); cyc();
        cnt_en = 1'b0;
        repeat (5) cyc();
        rd_cnt("R11 hold", 16'd10);
        cnt_en = 1'b1;
        cyc();
        rd_cnt("R11 divider kept", 16'd10);
        cyc();
        rd_cnt("R3 tick after resume", 16'd9);

        // periodic mode
        cnt_en = 1'b0; presc_sel = 2'd0;
        flag_clr = 1'b1;
        wr(16'd3);
        flag_clr = 1'b0;
        repeat (5) cyc();
        rd_cnt("R11 count", 16'd3);
        periodic_mode = 1'b1;
        wr(16'd6);
        rd_cnt("R5 count kept", 16'd3);
        rd_load("R5 load", 16'd6);
        cnt_en = 1'b1;
        cyc(); cyc();
        rd_cnt("R6 at one", 16'd1);
        chk("R7 not yet", {15'd0, zero_flag}, 16'd0);
        cyc();
        rd_cnt("R6 reload", 16'd6);
        chk("R7 set", {15'd0, zero_flag}, 16'd1);
        cnt_en = 1'b0;
        repeat (3) cyc();
        chk("R7 held", {15'd0, zero_flag}, 16'd1);
        flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
        chk("R7 cleared", {15'd0, zero_flag}, 16'd0);

        // coincident wrap, write and clear
        cnt_en = 1'b1;
        repeat (5) cyc();
        rd_cnt("R6 before wrap", 16'd1);
        flag_clr = 1'b1;
        wr(16'd9);
        flag_clr = 1'b0;
        cnt_en = 1'b0;
        rd_cnt("R6 new reload at wrap", 16'd9);
        chk("R7 set wins", {15'd0, zero_flag}, 16'd1);

        // R10 force load
        wr(16'd20);
        rd_cnt("R5 no change", 16'd9);
        force_load = 1'b1; cyc();
        rd_cnt("R10 force", 16'd20);
        wr(16'd33);
        force_load = 1'b0;
        rd_cnt("R10 force with write", 16'd33);

        // R8 R9 zero write
        flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
        latch_en = 1'b1; buf_en = 1'b1;
        wr(16'd0);
        chk("R9 latch pulse", {15'd0, latch_req}, 16'd1);
        rd_cnt("R8 parked", 16'd0);
        chk("R8 no flag", {15'd0, zero_flag}, 16'd0);
        cyc();
        chk("R9 one cycle", {15'd0, latch_req}, 16'd0);
        cnt_en = 1'b1;
        repeat (5) cyc();
        rd_cnt("R8 stays", 16'd0);
        chk("R8 flag low", {15'd0, zero_flag}, 16'd0);
        buf_en = 1'b0;
        wr(16'd0);
        chk("R9 no latch", {15'd0, latch_req}, 16'd0);
        periodic_mode = 1'b0; buf_en = 1'b1;
        wr(16'd5);
        wr(16'd0);
        rd_cnt("R8 single-run zero", 16'd0);
        chk("R9 single-run latch", {15'd0, latch_req}, 16'd1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule